// File: doc/BRIEF.md
# Collision-Checking Serial Transmitter

This block sends asynchronous serial frames onto a single wire that several nodes share. Each frame has a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then a high stop bit. Each bit lasts one transfer-clock period, which reaches the block as a one-cycle `tick_i` pulse. While a frame is out, the block compares the level it drives on TXD with the level read back on RXD. A difference raises a sticky collision request flag.

The comparison instant is selectable. It is either every transfer-clock tick, or a strobe from an external one-shot timer, so the sample point can be placed anywhere inside a bit. An optional auto-off mode drops the transmit enable as soon as a collision is flagged and abandons the frame.

A frame starts in one of two ways. In internal mode it starts one tick after the send condition is met. In edge mode it is launched by a chosen edge on RXD. A polarity control inverts both the driven and the read-back line.

Top module: `uart_bc_tx`

## Requirements
- R1: After reset, txd_o sits at idle level (1 with inv_pol_i=0), busy_o=0, flag_o=0 and te_o=0.
- R2: With edge_start_i=0, the send condition is te_o=1, loaded data and busy_o=0. When the condition holds at a tick, busy_o rises and TXD stays idle for one further tick period. TXD then carries the start bit (0), the data bits and the stop bit (1), one tick period each, and busy_o falls at the tick that ends the stop bit.
- R3: Data bits go out LSB first. len_sel_i is captured at launch: 0 selects 7 bits, 1 selects 8, 2 selects 9 and 3 selects 8.
- R4: inv_pol_i=1 inverts txd_o against the logical frame and inverts the RXD read-back the same way. An RXD looped back from TXD never raises a collision under either polarity.
- R5: With sample_sel_i=0, the driven and read-back levels are compared at every tick while a frame bit is on the line. A mismatch sets flag_o at that clock edge.
- R6: With sample_sel_i=1, the comparison happens only in cycles with tmr_strobe_i=1. Ticks alone never set flag_o.
- R7: flag_o stays set until flag_clr_i=1. A collision in the same cycle as a clear leaves flag_o set.
- R8: With auto_clr_i=1, te_o clears at the same edge that sets flag_o, even if te_set_i is high in that cycle. TXD returns to idle on the following cycle and busy_o falls at the next tick. With auto_clr_i=0, te_o is not touched by a collision.
- R9: With edge_start_i=1 and the send condition true, an RXD edge launches the frame. The edge is falling for inv_pol_i=0 and rising for inv_pol_i=1. The start bit appears on txd_o from the clock edge that first sees the new RXD level.
- R10: With edge_start_i=1, an RXD edge that arrives while the send condition is false is ignored, and ticks never launch a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per transfer-clock period |
| tmr_strobe_i | input | 1 | One-shot timer underflow strobe |
| sample_sel_i | input | 1 | 0: compare at tick, 1: compare at strobe |
| auto_clr_i | input | 1 | Clear transmit enable on collision |
| edge_start_i | input | 1 | 0: internal start, 1: RXD-edge start |
| inv_pol_i | input | 1 | Invert TXD and RXD |
| len_sel_i | input | 2 | Data length select |
| data_i | input | 9 | Data to transmit |
| load_i | input | 1 | Write data_i into the transmit buffer |
| te_set_i | input | 1 | Set transmit enable |
| te_clr_i | input | 1 | Clear transmit enable |
| flag_clr_i | input | 1 | Clear collision flag |
| rxd_i | input | 1 | Line read-back |
| txd_o | output | 1 | Serial output |
| flag_o | output | 1 | Bus collision request flag |
| busy_o | output | 1 | Frame in progress |
| te_o | output | 1 | Transmit enable state |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a collision and a software clear of the flag. The bench drives the timer strobe and flag_clr_i together during a mismatched bit and expects flag_o to stay set. The second pair is the automatic disable and a software set of the enable. The bench raises te_set_i together with a mismatching strobe under auto_clr_i=1 and expects te_o low, TXD idle on the next cycle and busy_o gone after the next tick. The edge-start checks give RXD edges both before and after the send condition holds, and only the second edge may launch a frame.

// File: rtl/uart_bc_pkg.sv
package uart_bc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  // frame position of the stop bit for a given length code
  function automatic int unsigned stop_pos(input logic [1:0] len_sel, input int unsigned data_w);
    case (len_sel)
      2'd0:    return data_w - 1;
      2'd2:    return data_w + 1;
      default: return data_w;
    endcase
  endfunction

endpackage

// File: rtl/uart_bc_ctl.sv
module uart_bc_ctl #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              edge_start_i,
  input  logic              inv_pol_i,
  input  logic              rxd_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              te_set_i,
  input  logic              te_clr_i,
  input  logic              auto_off_i,
  input  logic              busy_i,
  output logic              te_o,
  output logic              launch_o,
  output logic [DATA_W-1:0] data_o
);

  logic te_q, full_q, rxd_q;
  logic [DATA_W-1:0] buf_q;
  logic line_edge, send_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q <= 1'b0;
    end else if (auto_off_i) begin
      te_q <= 1'b0;
    end else if (te_set_i) begin
      te_q <= 1'b1;
    end else if (te_clr_i) begin
      te_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (load_i) begin
      full_q <= 1'b1;
      buf_q  <= data_i;
    end else if (launch_o) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_q <= 1'b1;
    else         rxd_q <= rxd_i;
  end

  assign line_edge = inv_pol_i ? (rxd_i & ~rxd_q) : (~rxd_i & rxd_q);
  assign send_ok   = te_q & full_q & ~busy_i;
  assign launch_o  = send_ok & (edge_start_i ? line_edge : tick_i);
  assign te_o      = te_q;
  assign data_o    = buf_q;

  assert_auto_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_off_i |=> !te_o);

endmodule

// File: rtl/uart_bc_frame.sv
module uart_bc_frame
  import uart_bc_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  localparam int unsigned POS_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              launch_i,
  input  logic              direct_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        len_i,
  input  logic              abort_i,
  input  logic              inv_pol_i,
  output logic              busy_o,
  output logic              active_o,
  output logic              txd_o
);

  tx_state_e         state_q;
  logic [POS_W-1:0]  pos_q, last_q;
  logic [DATA_W-1:0] sh_q;
  logic              abort_q, at_end, to_idle, lvl;

  assign at_end  = (pos_q == last_q);
  assign to_idle = (state_q == TX_SHIFT) & tick_i & (abort_q | at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      pos_q   <= '0;
      last_q  <= '0;
      sh_q    <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (launch_i) begin
          state_q <= direct_i ? TX_SHIFT : TX_ARM;
          pos_q   <= '0;
          sh_q    <= data_i;
          last_q  <= POS_W'(stop_pos(len_i, DATA_W));
        end
        TX_ARM: if (tick_i) state_q <= TX_SHIFT;
        TX_SHIFT: if (tick_i) begin
          if (abort_q || at_end) begin
            state_q <= TX_IDLE;
          end else begin
            pos_q <= pos_q + 1'b1;
            if (pos_q != '0) sh_q <= sh_q >> 1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               abort_q <= 1'b0;
    else if (to_idle)                          abort_q <= 1'b0;
    else if (abort_i && state_q == TX_SHIFT)   abort_q <= 1'b1;
  end

  always_comb begin
    lvl = 1'b1;
    if (state_q == TX_SHIFT && !abort_q) begin
      if (pos_q == '0)  lvl = 1'b0;
      else if (at_end)  lvl = 1'b1;
      else              lvl = sh_q[0];
    end
  end

  assign busy_o   = (state_q != TX_IDLE);
  assign active_o = (state_q == TX_SHIFT) & ~abort_q;
  assign txd_o    = lvl ^ inv_pol_i;

  assert_busy_ends_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));
  assert_abort_drops_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q && tick_i |=> !busy_o);
  assert_edge_launch_now_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && direct_i && !busy_o |=> active_o);

endmodule

// File: rtl/uart_bc_monitor.sv
module uart_bc_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic strobe_i,
  input  logic sample_sel_i,
  input  logic auto_clr_i,
  input  logic active_i,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic clr_i,
  output logic flag_o,
  output logic auto_off_o
);

  logic sample, mismatch, flag_q;

  assign sample     = active_i & (sample_sel_i ? strobe_i : tick_i);
  assign mismatch   = sample & (txd_i != rxd_i);
  assign auto_off_o = mismatch & auto_clr_i;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (mismatch) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_needs_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(sample));
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);

endmodule

// File: rtl/uart_bc_tx.sv
module uart_bc_tx #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tmr_strobe_i,
  input  logic              sample_sel_i,
  input  logic              auto_clr_i,
  input  logic              edge_start_i,
  input  logic              inv_pol_i,
  input  logic [1:0]        len_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  input  logic              te_set_i,
  input  logic              te_clr_i,
  input  logic              flag_clr_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              flag_o,
  output logic              busy_o,
  output logic              te_o
);

  logic              launch, auto_off, active;
  logic [DATA_W-1:0] buf_data;

  uart_bc_ctl #(.DATA_W(DATA_W)) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .edge_start_i (edge_start_i),
    .inv_pol_i    (inv_pol_i),
    .rxd_i        (rxd_i),
    .load_i       (load_i),
    .data_i       (data_i),
    .te_set_i     (te_set_i),
    .te_clr_i     (te_clr_i),
    .auto_off_i   (auto_off),
    .busy_i       (busy_o),
    .te_o         (te_o),
    .launch_o     (launch),
    .data_o       (buf_data)
  );

  uart_bc_frame #(.DATA_W(DATA_W)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .launch_i  (launch),
    .direct_i  (edge_start_i),
    .data_i    (buf_data),
    .len_i     (len_sel_i),
    .abort_i   (auto_off),
    .inv_pol_i (inv_pol_i),
    .busy_o    (busy_o),
    .active_o  (active),
    .txd_o     (txd_o)
  );

  uart_bc_monitor i_monitor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .strobe_i     (tmr_strobe_i),
    .sample_sel_i (sample_sel_i),
    .auto_clr_i   (auto_clr_i),
    .active_i     (active),
    .txd_i        (txd_o),
    .rxd_i        (rxd_i),
    .clr_i        (flag_clr_i),
    .flag_o       (flag_o),
    .auto_off_o   (auto_off)
  );

endmodule

// File: tb/test_uart_bc_tx.sv
module test_uart_bc_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 9;
  // {len_sel[1:0], inv_pol, data[8:0]}
  localparam logic [11:0] VECS [0:5] = '{
    {2'd1, 1'b0, 9'h0A5}, {2'd0, 1'b0, 9'h05A}, {2'd2, 1'b0, 9'h1C3},
    {2'd2, 1'b1, 9'h0F0}, {2'd3, 1'b0, 9'h155}, {2'd1, 1'b1, 9'h181}};

  logic clk = 0, rst_n = 0;
  logic tick, strobe = 0, sample_sel = 0, auto_clr = 0, edge_start = 0, inv_pol = 0;
  logic [1:0] len_sel = 2'd1;
  logic [DATA_W-1:0] data = '0;
  logic load = 0, te_set = 0, te_clr = 0, flag_clr = 0;
  logic loop_en = 1, rx_force = 1, rxd;
  logic txd, flag, busy, te;
  logic [1:0] tcnt;
  int n_checks = 0, n_err = 0;

  assign rxd = loop_en ? txd : rx_force;

  uart_bc_tx #(.DATA_W(DATA_W)) i_uart_bc_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tmr_strobe_i(strobe),
    .sample_sel_i(sample_sel), .auto_clr_i(auto_clr), .edge_start_i(edge_start),
    .inv_pol_i(inv_pol), .len_sel_i(len_sel), .data_i(data), .load_i(load),
    .te_set_i(te_set), .te_clr_i(te_clr), .flag_clr_i(flag_clr), .rxd_i(rxd),
    .txd_o(txd), .flag_o(flag), .busy_o(busy), .te_o(te));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else begin
      tcnt <= tcnt + 1'b1;
      tick <= (tcnt == 2'd2);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the next tick edge
  task automatic after_tick();
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 400; c++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_start_bit();
    for (int c = 0; c < 100; c++) begin
      if (busy && txd == inv_pol ^ 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic put_data(input logic [DATA_W-1:0] d, input logic set_te);
    @(negedge clk);
    data = d; load = 1; te_set = set_te;
    @(negedge clk);
    load = 0; te_set = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  task automatic run_vec(input logic [1:0] l, input logic p, input logic [DATA_W-1:0] d);
    logic [15:0] got, exp;
    int n, nb;
    bit seen;
    got = '0; exp = '0; n = 0; seen = 0;
    @(negedge clk);
    len_sel = l; inv_pol = p; loop_en = 1;
    put_data(d, 1'b1);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (busy) seen = 1;
      if (tick && busy) begin got[n] = txd ^ p; n++; end
      if (seen && !busy) break;
    end
    nb = (l == 2'd0) ? 7 : (l == 2'd2) ? 9 : 8;
    exp[0] = 1'b1;
    exp[1] = 1'b0;
    for (int i = 0; i < nb; i++) exp[i+2] = d[i];
    exp[nb+2] = 1'b1;
    chk("R2 frame bit count", n, nb + 3);
    chk("R3 frame bits LSB first", got, exp);
    chk("R4 loopback no collision", flag, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 busy", busy, 0);
    chk("R1 flag", flag, 0);
    chk("R1 te", te, 0);

    foreach (VECS[k]) run_vec(VECS[k][11:10], VECS[k][9], VECS[k][8:0]);

    // R5: tick sampling, no auto-off
    inv_pol = 0; loop_en = 0; rx_force = 1; len_sel = 2'd1;
    put_data('0, 1'b1);
    wait_start_bit();
    chk("R5 flag before sample", flag, 0);
    after_tick();
    chk("R5 flag on tick mismatch", flag, 1);
    chk("R8 te kept without auto", te, 1);
    wait_idle();
    clear_flag();
    chk("R7 flag cleared", flag, 0);

    // R6: strobe sampling; R7: collision beats clear
    sample_sel = 1;
    put_data('0, 1'b0);
    wait_start_bit();
    after_tick(); after_tick(); after_tick();
    chk("R6 ticks ignored", flag, 0);
    strobe = 1; flag_clr = 1;
    @(negedge clk);
    strobe = 0; flag_clr = 0;
    chk("R7 collision wins over clear", flag, 1);
    wait_idle();
    clear_flag();

    // R8: auto-off beats te_set
    auto_clr = 1;
    put_data('0, 1'b0);
    wait_start_bit();
    strobe = 1; te_set = 1;
    @(negedge clk);
    strobe = 0; te_set = 0;
    chk("R8 flag set", flag, 1);
    chk("R8 te forced off", te, 0);
    chk("R8 txd idle", txd, 1);
    chk("R8 busy until tick", busy, 1);
    after_tick();
    chk("R8 busy drops at tick", busy, 0);
    auto_clr = 0; sample_sel = 0;
    clear_flag();

    // R10: edge with condition false ignored
    edge_start = 1; loop_en = 0; rx_force = 1;
    put_data(9'h0C3, 1'b0);
    repeat (2) @(negedge clk);
    rx_force = 0;
    @(negedge clk);
    chk("R10 edge without enable ignored", busy, 0);
    rx_force = 1;
    @(negedge clk);
    te_set = 1;
    @(negedge clk);
    te_set = 0;
    after_tick(); after_tick(); after_tick();
    chk("R10 ticks do not launch", busy, 0);

    // R9: falling edge launches
    rx_force = 0;
    @(negedge clk);
    chk("R9 busy after falling edge", busy, 1);
    chk("R9 start bit after falling edge", txd, 0);
    loop_en = 1;
    wait_idle();
    chk("R9 frame clean", flag, 0);

    // R9: rising edge launches with inverted polarity
    inv_pol = 1; loop_en = 0; rx_force = 0;
    put_data(9'h03C, 1'b0);
    repeat (2) @(negedge clk);
    rx_force = 1;
    @(negedge clk);
    chk("R9 busy after rising edge", busy, 1);
    chk("R9 inverted start bit", txd, 1);
    loop_en = 1;
    wait_idle();
    chk("R9 inverted frame clean", flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule